// File: doc/BRIEF.md
# Tuner Control Register Slave on a Two-Wire Bus

This block is a fast-mode I2C slave that holds the six 8-bit control registers of a direct-conversion tuner. It presents their contents as parallel fields: the synthesizer divide value and the divide-by-2/4 choice, the reference code, the charge-pump code, the oscillator choice, the filter divider and fine-tune values, the output drive level, the converter controls, a diagnostic code and the baseband gain code. SCL and SDA pass through a synchronizer into the system clock domain. SDA is driven low through an open-drain enable. Three strap inputs select one of eight bus addresses, so several tuners can share one bus.

A write carries a register pointer and then data bytes. Each data byte lands at the pointer, and the pointer then steps forward. A read ignores the pointer. It returns a status byte, which holds a sticky power-cycle flag and a 3-bit tuning-voltage converter code, and then the filter fine-tune byte. The power-cycle flag is set by reset or by the power-on input, and it is cleared by a STOP that ends a read.

The control FSM has these states. ST_IDLE waits for START. ST_ADDR receives the address byte. ST_ADDR_ACK drives the acknowledge. ST_PTR and ST_PTR_ACK take the pointer. ST_WDATA and ST_WDATA_ACK take the data bytes. ST_RDATA shifts a byte out. ST_RACK samples the master's acknowledge. ST_WAIT ignores the bus.

The transitions are as follows:
- START from any state goes to ST_ADDR, and STOP from any state goes to ST_IDLE.
- ST_ADDR goes to ST_ADDR_ACK on an address match and to ST_WAIT on a mismatch.
- ST_ADDR_ACK goes to ST_RDATA for a read and to ST_PTR for a write.
- ST_PTR goes to ST_PTR_ACK, then to ST_WDATA.
- ST_WDATA goes to ST_WDATA_ACK, then back to ST_WDATA.
- ST_RDATA goes to ST_RACK. ST_RACK goes back to ST_RDATA on an ACK and to ST_WAIT on a NACK.

Top module: `tuner_cfg_i2c`

## Requirements
- R1: The 7-bit device address is 4'b1100 followed by strap_sel[2:0], and the eighth address bit is 1 for a read. Only a matching address byte is acknowledged; any other transfer leaves SDA released and the registers unchanged.
- R2: After reset the registers read 0=03h, 1=B6h, 2=3Dh, 3=7Fh, 4=02h and 5=1Fh. This gives n_div=950 and div2_sel=0.
- R3: The fields are mapped as follows:
  - reg0: div2_sel=bit 7; n_div={reg0[6:0],reg1[7:0]}.
  - reg2: r_code=[7:5], cp_code=[4:3], osc_sel=[2:0].
  - reg3: fdac_spare=bit 7, fdac=[6:0].
  - reg4: adc_latch=bit 7, adc_en=bit 6, drive_lvl=bit 5, m_div=[4:0].
  - reg5: diag=[7:5], bb_gain=[4:0].
- R4: A write consists of the address byte, a pointer byte and then data bytes. Each data byte is stored at the pointer, and the pointer then advances by one. All bytes are MSB first and all are acknowledged.
- R5: A data byte sent to a pointer above 05h is acknowledged and discarded. The pointer does not wrap back to 00h.
- R6: A read returns the status byte first and then {1'b0, fdac}. Any further bytes repeat the fdac byte.
- R7: The status byte holds the power-cycle flag in bit 7, zeros in [6:3] and the held converter code in [2:0]. The held code follows adc_code every clock while adc_latch=1 and keeps its value while adc_latch=0. Bits [2:0] read 000 while adc_en=0.
- R8: The power-cycle flag is set by reset and by por_flag. por_flag also reloads every register with its reset value. The flag is cleared by a STOP that ends a read.
- R9: A NACK from the master after a read byte makes the slave release SDA and ignore the bus until STOP or START.
- R10: A repeated START returns the slave to address matching and leaves the register contents unchanged.
- R11: SDA is released in ST_IDLE and in ST_WAIT. The slave changes sda_oe only while SCL is low, or when it releases SDA on START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe | output | 1 | 1 pulls SDA low |
| strap_sel | input | 3 | Low three address bits |
| adc_code | input | 3 | Tuning-voltage converter code |
| por_flag | input | 1 | Power-cycle indication; reloads the registers |
| div2_sel | output | 1 | 1 selects divide-by-2, 0 selects divide-by-4 |
| n_div | output | 15 | Synthesizer divide value |
| r_code | output | 3 | Reference divider code |
| cp_code | output | 2 | Charge-pump current code |
| osc_sel | output | 3 | Oscillator choice |
| fdac_spare | output | 1 | Unused bit of the filter register |
| fdac | output | 7 | Filter fine-tune value |
| adc_latch | output | 1 | Converter latch enable |
| adc_en | output | 1 | Converter readout enable |
| drive_lvl | output | 1 | Baseband drive level |
| m_div | output | 5 | Filter clock divider |
| diag | output | 3 | Diagnostic code |
| bb_gain | output | 5 | Baseband gain code |

## Verification
The hardest case to reach is the behaviour of the held converter code. Showing that the code holds once adc_latch falls needs a write that clears the latch bit while the input still carries the old code. The input then has to change before the read, so that a stale value is told apart from a live one. The stimulus writes register 4 with the latch set, reads once, writes register 4 again with the latch cleared, changes adc_code and reads again. A master NACK followed by further clocks, and a repeated START placed after the pointer byte, are both driven directly from the bus model.

// File: rtl/tcfg_pkg.sv
package tcfg_pkg;
    localparam int NUM_REGS = 6;
    localparam int PTR_W    = 8;
    localparam int ADC_W    = 3;
    localparam int CTRL_IDX = 4;
    localparam logic [3:0] DEV_HI = 4'b1100;

    typedef enum logic [3:0] {
        ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_PTR, ST_PTR_ACK,
        ST_WDATA, ST_WDATA_ACK, ST_RDATA, ST_RACK, ST_WAIT
    } st_e;

    function automatic logic [7:0] rst_byte(input int idx);
        case (idx)
            0:       return 8'h03;
            1:       return 8'hB6;
            2:       return 8'h3D;
            3:       return 8'h7F;
            4:       return 8'h02;
            default: return 8'h1F;
        endcase
    endfunction
endpackage

// File: rtl/tcfg_pin_sync.sv
module tcfg_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe, sda_pipe;
    logic scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_q    <= scl_pipe[STAGES-1];
            sda_q    <= sda_pipe[STAGES-1];
        end
    end

    assign scl_s     = scl_pipe[STAGES-1];
    assign sda_s     = sda_pipe[STAGES-1];
    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/tcfg_regs.sv
module tcfg_regs
    import tcfg_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     por,
    input  logic                     we,
    input  logic [PTR_W-1:0]         waddr,
    input  logic [7:0]               wdata,
    input  logic [ADC_W-1:0]         adc_code,
    input  logic                     rd_stop,
    output logic [NUM_REGS-1:0][7:0] regs,
    output logic [7:0]               status_byte,
    output logic                     pwr_flag,
    output logic [ADC_W-1:0]         adc_hold
);
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                regs[g] <= rst_byte(g);
            else if (por)                              regs[g] <= rst_byte(g);
            else if (we && waddr == PTR_W'(g))         regs[g] <= wdata;
        end
    end

    logic latch_on, read_on;
    assign latch_on = regs[CTRL_IDX][7];
    assign read_on  = regs[CTRL_IDX][6];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            adc_hold <= '0;
            pwr_flag <= 1'b1;
        end else begin
            if (latch_on) adc_hold <= adc_code;
            if (por)          pwr_flag <= 1'b1;
            else if (rd_stop) pwr_flag <= 1'b0;
        end
    end

    assign status_byte = {pwr_flag, {(7-ADC_W){1'b0}}, read_on ? adc_hold : {ADC_W{1'b0}}};
endmodule

// File: rtl/tuner_cfg_i2c.sv
module tuner_cfg_i2c
    import tcfg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        scl_i,
    input  logic        sda_i,
    output logic        sda_oe,
    input  logic [2:0]  strap_sel,
    input  logic [2:0]  adc_code,
    input  logic        por_flag,
    output logic        div2_sel,
    output logic [14:0] n_div,
    output logic [2:0]  r_code,
    output logic [1:0]  cp_code,
    output logic [2:0]  osc_sel,
    output logic        fdac_spare,
    output logic [6:0]  fdac,
    output logic        adc_latch,
    output logic        adc_en,
    output logic        drive_lvl,
    output logic [4:0]  m_div,
    output logic [2:0]  diag,
    output logic [4:0]  bb_gain
);
    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

    tcfg_pin_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    st_e state, nxt;
    logic [2:0]       bit_cnt;
    logic             full, rd_mode;
    logic [7:0]       sr, tx;
    logic [PTR_W-1:0] ptr;
    logic             we, rd_stop, addr_hit, pwr_flag;
    logic [NUM_REGS-1:0][7:0] regs;
    logic [7:0]       status_byte, filt_byte;
    logic [ADC_W-1:0] adc_hold;

    assign addr_hit  = (sr[7:1] == {DEV_HI, strap_sel});
    assign we        = (state == ST_WDATA) && scl_fall && full && (ptr < PTR_W'(NUM_REGS));
    assign rd_stop   = stop_det && rd_mode;
    assign filt_byte = {1'b0, regs[3][6:0]};

    tcfg_regs u_regs (
        .clk(clk), .rst_n(rst_n), .por(por_flag), .we(we), .waddr(ptr), .wdata(sr),
        .adc_code(adc_code), .rd_stop(rd_stop), .regs(regs),
        .status_byte(status_byte), .pwr_flag(pwr_flag), .adc_hold(adc_hold)
    );

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:      nxt = ST_IDLE;
            ST_ADDR:      if (scl_fall && full) nxt = addr_hit ? ST_ADDR_ACK : ST_WAIT;
            ST_ADDR_ACK:  if (scl_fall) nxt = rd_mode ? ST_RDATA : ST_PTR;
            ST_PTR:       if (scl_fall && full) nxt = ST_PTR_ACK;
            ST_PTR_ACK:   if (scl_fall) nxt = ST_WDATA;
            ST_WDATA:     if (scl_fall && full) nxt = ST_WDATA_ACK;
            ST_WDATA_ACK: if (scl_fall) nxt = ST_WDATA;
            ST_RDATA:     if (scl_fall && full) nxt = ST_RACK;
            ST_RACK: begin
                if (scl_rise && sda_s)      nxt = ST_WAIT;
                else if (scl_fall && full)  nxt = ST_RDATA;
            end
            ST_WAIT:      nxt = ST_WAIT;
            default:      nxt = ST_IDLE;
        endcase
        if (start_det)     nxt = ST_ADDR;
        else if (stop_det) nxt = ST_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            full    <= 1'b0;
            sr      <= '0;
            tx      <= '0;
            sda_oe  <= 1'b0;
            ptr     <= '0;
            rd_mode <= 1'b0;
        end else if (start_det || stop_det) begin
            bit_cnt <= '0;
            full    <= 1'b0;
            sda_oe  <= 1'b0;
            rd_mode <= 1'b0;
        end else begin
            unique case (state)
                ST_ADDR, ST_PTR, ST_WDATA: begin
                    if (scl_rise) begin
                        sr      <= {sr[6:0], sda_s};
                        bit_cnt <= bit_cnt + 3'd1;
                        if (bit_cnt == 3'd7) full <= 1'b1;
                    end else if (scl_fall && full) begin
                        full    <= 1'b0;
                        bit_cnt <= '0;
                        if (state == ST_ADDR) begin
                            sda_oe <= addr_hit;
                            if (addr_hit) rd_mode <= sr[0];
                        end else begin
                            sda_oe <= 1'b1;
                            if (state == ST_PTR)  ptr <= sr;
                            else if (ptr != '1)   ptr <= ptr + 1'b1;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        if (rd_mode) begin
                            tx     <= status_byte;
                            sda_oe <= ~status_byte[7];
                        end else begin
                            sda_oe <= 1'b0;
                        end
                    end
                end
                ST_PTR_ACK, ST_WDATA_ACK: begin
                    if (scl_fall) sda_oe <= 1'b0;
                end
                ST_RDATA: begin
                    if (scl_rise) begin
                        bit_cnt <= bit_cnt + 3'd1;
                        if (bit_cnt == 3'd7) full <= 1'b1;
                    end else if (scl_fall) begin
                        if (full) begin
                            full    <= 1'b0;
                            bit_cnt <= '0;
                            sda_oe  <= 1'b0;
                        end else begin
                            tx     <= {tx[6:0], 1'b0};
                            sda_oe <= ~tx[6];
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        full <= ~sda_s;
                    end else if (scl_fall && full) begin
                        full   <= 1'b0;
                        tx     <= filt_byte;
                        sda_oe <= ~filt_byte[7];
                    end
                end
                default: sda_oe <= 1'b0;
            endcase
        end
    end

    assign div2_sel   = regs[0][7];
    assign n_div      = {regs[0][6:0], regs[1]};
    assign r_code     = regs[2][7:5];
    assign cp_code    = regs[2][4:3];
    assign osc_sel    = regs[2][2:0];
    assign fdac_spare = regs[3][7];
    assign fdac       = regs[3][6:0];
    assign adc_latch  = regs[4][7];
    assign adc_en     = regs[4][6];
    assign drive_lvl  = regs[4][5];
    assign m_div      = regs[4][4:0];
    assign diag       = regs[5][7:5];
    assign bb_gain    = regs[5][4:0];
endmodule

// File: rtl/tcfg_chk.sv
module tcfg_chk
    import tcfg_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input st_e              state,
    input logic             sda_oe,
    input logic             scl_s,
    input logic             start_det,
    input logic             stop_det,
    input logic             rd_mode,
    input logic             por_flag,
    input logic             pwr_flag,
    input logic             adc_latch,
    input logic [ADC_W-1:0] adc_hold,
    input logic [14:0]      n_div
);
    // R11
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_oe);

    // R11
    scl_high_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s) && !$past(start_det) && !$past(stop_det)) |-> $stable(sda_oe));

    // R9
    wait_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT) |-> !sda_oe);

    // R8
    pwr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && rd_mode && !por_flag) |=> !pwr_flag);

    // R8
    por_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        por_flag |=> (pwr_flag && n_div == 15'd950));

    // R7
    adc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_latch |=> $stable(adc_hold));
endmodule

bind tuner_cfg_i2c tcfg_chk u_chk (
    .clk(clk), .rst_n(rst_n), .state(state), .sda_oe(sda_oe), .scl_s(scl_s),
    .start_det(start_det), .stop_det(stop_det), .rd_mode(rd_mode),
    .por_flag(por_flag), .pwr_flag(pwr_flag), .adc_latch(adc_latch),
    .adc_hold(adc_hold), .n_div(n_div)
);

// File: tb/tuner_cfg_i2c_tb.sv
`timescale 1ns/1ps
module tuner_cfg_i2c_tb;
    localparam int H = 8;
    localparam int NV = 8;
    localparam logic [15:0] WVEC [NV] = '{
        16'h00_9A, 16'h01_23, 16'h02_C7, 16'h03_D5,
        16'h04_1F, 16'h05_E9, 16'h06_55, 16'h02_3D
    };

    logic clk = 0, rst_n = 0;
    logic scl_m = 1, sda_m = 1, por_flag = 0;
    logic [2:0] strap_sel = 3'd0, adc_code = 3'd0;
    logic sda_oe, sda_i;
    logic div2_sel, fdac_spare, adc_latch, adc_en, drive_lvl;
    logic [14:0] n_div;
    logic [2:0] r_code, osc_sel, diag;
    logic [1:0] cp_code;
    logic [6:0] fdac;
    logic [4:0] m_div, bb_gain;
    int checks = 0, failures = 0;
    bit done = 0;
    logic [7:0] shadow [6];

    assign sda_i = sda_m & ~sda_oe;

    always #2 clk = ~clk;

    tuner_cfg_i2c u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_i), .sda_oe(sda_oe),
        .strap_sel(strap_sel), .adc_code(adc_code), .por_flag(por_flag),
        .div2_sel(div2_sel), .n_div(n_div), .r_code(r_code), .cp_code(cp_code),
        .osc_sel(osc_sel), .fdac_spare(fdac_spare), .fdac(fdac), .adc_latch(adc_latch),
        .adc_en(adc_en), .drive_lvl(drive_lvl), .m_div(m_div), .diag(diag), .bb_gain(bb_gain)
    );

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    task automatic wait_h(input int n);
        repeat (n*H) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1; wait_h(1); scl_m = 1; wait_h(1);
        sda_m = 0; wait_h(1); scl_m = 0; wait_h(1);
    endtask

    task automatic bus_stop();
        sda_m = 0; wait_h(1); scl_m = 1; wait_h(1); sda_m = 1; wait_h(2);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wait_h(1); scl_m = 1; wait_h(2); scl_m = 0; wait_h(1);
        end
        sda_m = 1; wait_h(1); scl_m = 1; wait_h(1); ack = sda_i; wait_h(1); scl_m = 0; wait_h(1);
    endtask

    task automatic recv_byte(input bit m_ack, output logic [7:0] b);
        sda_m = 1;
        for (int i = 7; i >= 0; i--) begin
            wait_h(1); scl_m = 1; wait_h(1); b[i] = sda_i; wait_h(1); scl_m = 0; wait_h(1);
        end
        sda_m = m_ack ? 1'b0 : 1'b1; wait_h(1); scl_m = 1; wait_h(2); scl_m = 0; wait_h(1);
        sda_m = 1;
    endtask

    // write n bytes (MSB-first in d) starting at ptr; returns OR of all ack bits
    task automatic wr(input logic [7:0] dev, input logic [7:0] ptr, input logic [23:0] d,
                      input int n, output logic nack);
        logic a;
        bus_start();
        send_byte(dev, a); nack = a;
        send_byte(ptr, a); nack |= a;
        for (int k = 0; k < n; k++) begin
            send_byte(d[23-8*k -: 8], a); nack |= a;
            if (dev == {4'b1100, strap_sel, 1'b0} && (ptr + k) < 6) shadow[ptr+k] = d[23-8*k -: 8];
        end
        bus_stop();
    endtask

    task automatic rd(input logic [7:0] dev, output logic [7:0] s, output logic [7:0] f);
        logic a;
        bus_start();
        send_byte(dev, a);
        recv_byte(1'b1, s);
        recv_byte(1'b0, f);
        bus_stop();
    endtask

    task automatic check_fields(input string req);
        chk(req, {div2_sel, n_div, r_code, cp_code, osc_sel, fdac_spare, fdac,
                  adc_latch, adc_en, drive_lvl, m_div, diag, bb_gain},
            {shadow[0], shadow[1], shadow[2], shadow[3], shadow[4], shadow[5]});
    endtask

    task automatic model_reset();
        shadow[0] = 8'h03; shadow[1] = 8'hB6; shadow[2] = 8'h3D;
        shadow[3] = 8'h7F; shadow[4] = 8'h02; shadow[5] = 8'h1F;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic nk, a;
        logic [7:0] s, f, x;
        model_reset();
        repeat (5) @(negedge clk);
        rst_n = 1;
        repeat (5) @(negedge clk);

        // R2 R3 reset state
        check_fields("R2");
        chk("R2 n_div", n_div, 15'd950);
        chk("R11 idle release", sda_oe, 0);

        // R6 R8 first read: PWR set, adc_en=0
        adc_code = 3'b101;
        rd(8'hC1, s, f);
        chk("R8 pwr set", s, 8'h80);
        chk("R6 filter byte", f, {1'b0, shadow[3][6:0]});
        rd(8'hC1, s, f);
        chk("R8 pwr cleared by stop", s, 8'h00);

        // R3 R4 R5 vector table
        for (int v = 0; v < NV; v++) begin
            wr(8'hC0, WVEC[v][15:8], {WVEC[v][7:0], 16'h0}, 1, nk);
            chk("R4 ack (R5 for ptr 06)", nk, 0);
            check_fields("R3");
        end

        // R4 burst auto-increment
        wr(8'hC0, 8'h03, 24'h112233, 3, nk);
        chk("R4 burst ack", nk, 0);
        check_fields("R4 burst");
        // R5 run past the last register
        wr(8'hC0, 8'h05, 24'h446600, 3, nk);
        chk("R5 ack past end", nk, 0);
        check_fields("R5 discard");

        // R7 converter latch/enable
        adc_code = 3'b110;
        wr(8'hC0, 8'h04, {8'hE2, 16'h0}, 1, nk);
        repeat (4) @(negedge clk);
        rd(8'hC1, s, f);
        chk("R7 latched code", s, 8'h06);
        wr(8'hC0, 8'h04, {8'h62, 16'h0}, 1, nk);
        adc_code = 3'b001;
        repeat (4) @(negedge clk);
        rd(8'hC1, s, f);
        chk("R7 hold when latch off", s, 8'h06);
        wr(8'hC0, 8'h04, {8'h22, 16'h0}, 1, nk);
        rd(8'hC1, s, f);
        chk("R7 zero when readout off", s, 8'h00);

        // R1 strap address
        strap_sel = 3'b011;
        wr(8'hC6, 8'h01, {8'h44, 16'h0}, 1, nk);
        chk("R1 strap ack", nk, 0);
        check_fields("R1 strap write");
        bus_start(); send_byte(8'hC0, a); bus_stop();
        chk("R1 mismatch nack", a, 1);
        wr(8'hC0, 8'h02, {8'hFF, 16'h0}, 1, nk);
        check_fields("R1 mismatch ignored");
        rd(8'hC7, s, f);
        chk("R1 strap read filter", f, {1'b0, shadow[3][6:0]});
        strap_sel = 3'b000;

        // R9 master NACK then extra clocks
        bus_start(); send_byte(8'hC1, a);
        recv_byte(1'b0, s);
        recv_byte(1'b0, x);
        bus_stop();
        chk("R9 released after nack", x, 8'hFF);

        // R10 repeated start after pointer byte
        bus_start(); send_byte(8'hC0, a); send_byte(8'h00, a);
        bus_start(); send_byte(8'hC0, a); send_byte(8'h01, a); send_byte(8'h99, a);
        bus_stop();
        shadow[1] = 8'h99;
        chk("R10 ack after Sr", a, 0);
        check_fields("R10");

        // R8 power-on input
        @(negedge clk); por_flag = 1; @(negedge clk); por_flag = 0;
        repeat (3) @(negedge clk);
        model_reset();
        check_fields("R8 por reload");
        rd(8'hC1, s, f);
        chk("R8 por sets pwr", s, 8'h80);

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule